// File: doc/BRIEF.md
# Buffered Configuration Port Controller

This block is a memory-mapped peripheral placed between a 32-bit processor bus and a word-wide device configuration port. It holds a 512-word staging buffer and a small set of control and status registers. Software loads the buffer over the bus, programs a transfer length in bytes and a starting word position inside the buffer, and then writes the direction register. That write selects the direction and starts the transfer in the same step.

In the configure direction the controller reads words out of the buffer and presents them on a valid/ready output channel. In the readback direction it accepts words from a valid/ready input channel and stores them in the buffer. Software watches a single status word. It carries a done flag, four constant ones and four flags mirrored from the port. A write to the status location cancels any transfer in progress.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset the status done bit (bit 0) reads 1, the size register reads 0, the offset register reads 0, and neither port channel is active.
- R2: A bus write to byte address A in 0x000..0x7FC stores a word in buffer entry A>>2. A bus read returns that entry on bus_rdata in the cycle after the read request. All bus reads have this one-cycle latency.
- R3: The size register (byte address 0x800, 12 bits) and the offset register (0x804, 9 bits) read back what was written. Bits 1:0 of size are stored but do not count, so a transfer moves size>>2 words.
- R4: Writing 0 in bit 0 of the direction register (0x808) streams buffer entries offset, offset+1, ... in order on cp_out_data, one per cp_out_valid/cp_out_ready handshake. The input channel stays idle during this.
- R5: Writing 1 in bit 0 of the direction register stores each word accepted on cp_in_valid/cp_in_ready into buffer entries offset, offset+1, ... in order.
- R6: The status word at 0x80C holds done in bit 0 and ones in bits 4:1. Bit 5 mirrors cp_abort_n, bit 6 mirrors cp_rb_busy, bit 7 mirrors cp_aligned and bit 8 mirrors cp_err. All other bits are 0.
- R7: Done reads 0 from the clock edge that takes a direction write until the last word has been handshaked. It reads 1 again from the following cycle.
- R8: A direction write while a transfer is active is ignored. The running transfer keeps its direction and word count.
- R9: The buffer position stops at entry 511. Words beyond it all use entry 511 and do not wrap to entry 0.
- R10: A direction write with size>>2 equal to 0 starts no port activity and leaves done at 1.
- R11: A bus write to 0x80C returns the sequencer to idle at once. From the next cycle no port handshake is offered and done reads 1.
- R12: While a transfer is active, bus writes to the buffer are dropped and bus reads of the buffer return 0.
- R13: While cp_out_valid is high and cp_out_ready is low, cp_out_valid stays high and cp_out_data stays unchanged on the next cycle, unless a status write cancels the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| cp_out_valid | output | 1 | Configure word offered to the port |
| cp_out_ready | input | 1 | Port accepts the configure word |
| cp_out_data | output | 32 | Configure word |
| cp_in_valid | input | 1 | Port offers a readback word |
| cp_in_ready | output | 1 | Controller accepts a readback word |
| cp_in_data | input | 32 | Readback word |
| cp_abort_n | input | 1 | Port abort flag, active low, mirrored in status |
| cp_rb_busy | input | 1 | Port readback-in-progress flag, mirrored in status |
| cp_aligned | input | 1 | Port data-aligned flag, mirrored in status |
| cp_err | input | 1 | Port configuration-error flag, mirrored in status |

## Verification
A wrong position or count in the sequencer shows up as soon as the transfer ends. The word stream on the output channel, or the buffer contents read back afterwards, differs from the model. The error can also show earlier, as a done flag that never returns or returns early at the next status poll. A stuck or stale state after a cancel or an ignored start shows within a few cycles, as an unexpected handshake on a channel that should be silent. Buffer access lockout is checked by reading the buffer while a stalled transfer holds the sequencer busy.

// File: rtl/cfgp_pkg.sv
// Shared definitions for the buffered configuration port controller.
// Assumes the register window sits directly above the buffer window.
package cfgp_pkg;
    // Register select, taken from byte address bits 3:2 in the register window
    typedef enum logic [1:0] {
        RSEL_SIZE = 2'd0,
        RSEL_OFFS = 2'd1,
        RSEL_DIR  = 2'd2,
        RSEL_STAT = 2'd3
    } rsel_t;

    // Transfer sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_SEND  = 2'd2,
        SQ_RECV  = 2'd3
    } sq_state_t;

    localparam logic [3:0] STAT_ONES = 4'b1111;
endpackage

// File: rtl/cfgp_regs.sv
// Bus decode and the size/offset registers.
// Assumes word address bit AW marks the register window. Only the four words
// at the bottom of that window decode.
module cfgp_regs
    import cfgp_pkg::*;
#(
    parameter int AW  = 9,
    parameter int SZW = 12,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_sel,
    input  logic           bus_we,
    input  logic [AW:0]    bus_word,
    input  logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  stat_word,
    output logic           hit_buf,
    output logic           start_req,
    output logic           start_dir,
    output logic           abort_req,
    output logic [SZW-1:0] size_q,
    output logic [AW-1:0]  offs_q,
    output logic [DW-1:0]  reg_rdata
);
    logic  hit_reg;
    rsel_t rsel;

    // Window decode
    always_comb begin
        hit_buf = bus_sel && !bus_word[AW];
        hit_reg = bus_sel && bus_word[AW] && (bus_word[AW-1:2] == '0);
        rsel    = rsel_t'(bus_word[1:0]);
    end

    // One-cycle strobes towards the sequencer
    always_comb begin
        start_req = hit_reg && bus_we && (rsel == RSEL_DIR);
        start_dir = bus_wdata[0];
        abort_req = hit_reg && bus_we && (rsel == RSEL_STAT);
    end

    // Size and offset register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
            offs_q <= '0;
        end else if (hit_reg && bus_we) begin
            if (rsel == RSEL_SIZE) size_q <= bus_wdata[SZW-1:0];
            if (rsel == RSEL_OFFS) offs_q <= bus_wdata[AW-1:0];
        end
    end

    // Register read mux (registered by the top)
    always_comb begin
        reg_rdata = '0;
        if (hit_reg) begin
            case (rsel)
                RSEL_SIZE: reg_rdata = DW'(size_q);
                RSEL_OFFS: reg_rdata = DW'(offs_q);
                RSEL_STAT: reg_rdata = stat_word;
                default:   reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cfgp_buffer.sv
// Staging buffer with one write port and one registered read port.
// The contents have no reset. The read register changes only when re is high.
module cfgp_buffer #(
    parameter int DEPTH = 512,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Write port
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/cfgp_seq.sv
// Transfer sequencer. Moves cnt_in words between the buffer and the port,
// starting at entry offs_in. The buffer position saturates at the last entry.
// Assumes start and abort are never high in the same cycle.
module cfgp_seq
    import cfgp_pkg::*;
#(
    parameter int AW = 9,
    parameter int DW = 32,
    localparam int CW = AW + 1,
    localparam logic [AW-1:0] LAST = {AW{1'b1}}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir_rb,
    input  logic          abort,
    input  logic [CW-1:0] cnt_in,
    input  logic [AW-1:0] offs_in,
    output logic          active,
    output logic          out_valid,
    input  logic          out_ready,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          mem_re,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    sq_state_t     state;
    logic [CW-1:0] cnt;
    logic [AW-1:0] pos;
    logic          step;

    // Handshake and buffer strobes derived from state
    always_comb begin
        active    = (state != SQ_IDLE);
        out_valid = (state == SQ_SEND);
        in_ready  = (state == SQ_RECV);
        mem_re    = (state == SQ_FETCH);
        mem_we    = in_ready && in_valid;
        mem_addr  = pos;
        mem_wdata = in_data;
        step      = (out_valid && out_ready) || mem_we;
    end

    // State, remaining count and buffer position
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state <= SQ_IDLE;
            cnt   <= '0;
            pos   <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (start && cnt_in != '0) begin
                    cnt   <= cnt_in;
                    pos   <= offs_in;
                    state <= dir_rb ? SQ_RECV : SQ_FETCH;
                end
                SQ_FETCH: state <= SQ_SEND;
                default: if (step) begin
                    cnt <= cnt - 1'b1;
                    if (pos != LAST) pos <= pos + 1'b1;
                    if (cnt == CW'(1))          state <= SQ_IDLE;
                    else if (state == SQ_SEND)  state <= SQ_FETCH;
                end
            endcase
        end
    end
endmodule

// File: rtl/cfg_port_ctrl.sv
// Buffered configuration port controller, top level.
// Joins bus decode, staging buffer and sequencer. The sequencer owns the
// buffer while a transfer is active. Bus reads have one cycle of latency.
module cfg_port_ctrl
    import cfgp_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int BAW  = AW + 3,
    localparam int SZW  = AW + 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_sel,
    input  logic           bus_we,
    input  logic [BAW-1:0] bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           cp_out_valid,
    input  logic           cp_out_ready,
    output logic [DW-1:0]  cp_out_data,
    input  logic           cp_in_valid,
    output logic           cp_in_ready,
    input  logic [DW-1:0]  cp_in_data,
    input  logic           cp_abort_n,
    input  logic           cp_rb_busy,
    input  logic           cp_aligned,
    input  logic           cp_err
);
    logic [AW:0]    bus_word;
    logic           hit_buf, start_req, start_dir, abort_req;
    logic [SZW-1:0] size_q;
    logic [AW-1:0]  offs_q;
    logic [DW-1:0]  reg_rdata, stat_word, buf_q;
    logic           active, seq_re, seq_we;
    logic [AW-1:0]  seq_addr;
    logic [DW-1:0]  seq_wdata;
    logic           buf_re, buf_we;
    logic [AW-1:0]  buf_raddr, buf_waddr;
    logic [DW-1:0]  buf_wdata;
    logic           rd_buf_q;
    logic [DW-1:0]  rd_reg_q;

    // Status word assembly
    always_comb begin
        bus_word  = bus_addr[BAW-1:2];
        stat_word = '0;
        stat_word[8:0] = {cp_err, cp_aligned, cp_rb_busy, cp_abort_n, STAT_ONES, !active};
    end

    cfgp_regs #(.AW(AW), .SZW(SZW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .stat_word(stat_word),
        .hit_buf(hit_buf), .start_req(start_req), .start_dir(start_dir),
        .abort_req(abort_req), .size_q(size_q), .offs_q(offs_q),
        .reg_rdata(reg_rdata)
    );

    cfgp_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start_req), .dir_rb(start_dir),
        .abort(abort_req), .cnt_in(size_q[SZW-1:2]), .offs_in(offs_q),
        .active(active), .out_valid(cp_out_valid), .out_ready(cp_out_ready),
        .in_valid(cp_in_valid), .in_ready(cp_in_ready), .in_data(cp_in_data),
        .mem_re(seq_re), .mem_we(seq_we), .mem_addr(seq_addr),
        .mem_wdata(seq_wdata)
    );

    // Buffer port arbitration: sequencer while active, bus otherwise
    always_comb begin
        buf_re    = active ? seq_re : (hit_buf && !bus_we);
        buf_raddr = active ? seq_addr : bus_word[AW-1:0];
        buf_we    = active ? seq_we : (hit_buf && bus_we);
        buf_waddr = active ? seq_addr : bus_word[AW-1:0];
        buf_wdata = active ? seq_wdata : bus_wdata;
    end

    cfgp_buffer #(.DEPTH(DEPTH), .DW(DW)) u_buf (
        .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
        .re(buf_re), .raddr(buf_raddr), .rdata(buf_q)
    );

    // Read return path, one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_buf_q <= 1'b0;
            rd_reg_q <= '0;
        end else begin
            rd_buf_q <= hit_buf && !bus_we && !active;
            rd_reg_q <= (bus_sel && !bus_we) ? reg_rdata : '0;
        end
    end

    // Output data steering
    always_comb begin
        bus_rdata   = rd_buf_q ? buf_q : rd_reg_q;
        cp_out_data = buf_q;
    end
endmodule

// File: rtl/cfg_port_ctrl_chk.sv
// Property checker for cfg_port_ctrl, attached by bind. Sees top ports only.
module cfg_port_ctrl_chk #(
    parameter int BAW = 12,
    parameter int DW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_sel,
    input logic           bus_we,
    input logic [BAW-1:0] bus_addr,
    input logic           cp_out_valid,
    input logic           cp_out_ready,
    input logic [DW-1:0]  cp_out_data,
    input logic           cp_in_ready
);
    localparam logic [BAW-1:0] STAT_ADDR = BAW'(12'h80C);
    localparam logic [BAW-1:0] DIR_ADDR  = BAW'(12'h808);

    logic stat_wr, dir_wr, first_cyc;

    // Decoded bus strobes seen at the ports
    always_comb begin
        stat_wr = bus_sel && bus_we && (bus_addr[BAW-1:2] == STAT_ADDR[BAW-1:2]);
        dir_wr  = bus_sel && bus_we && (bus_addr[BAW-1:2] == DIR_ADDR[BAW-1:2]);
    end

    // Marks the first cycle after reset release
    always_ff @(posedge clk) begin
        if (!rst_n) first_cyc <= 1'b1;
        else        first_cyc <= 1'b0;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        first_cyc |-> (!cp_out_valid && !cp_in_ready)); // R1

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(cp_out_valid && cp_in_ready)); // R4

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_out_valid && !cp_out_ready && !stat_wr) |=>
            (cp_out_valid && $stable(cp_out_data))); // R13

    AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (!cp_out_valid && !cp_in_ready)); // R11

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_wr && cp_out_valid && !cp_out_ready) |=> !cp_in_ready); // R8
endmodule

bind cfg_port_ctrl cfg_port_ctrl_chk #(.BAW(BAW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .cp_out_valid(cp_out_valid),
    .cp_out_ready(cp_out_ready), .cp_out_data(cp_out_data),
    .cp_in_ready(cp_in_ready)
);

// File: tb/cfg_port_ctrl_test.sv
// Self-checking bench for cfg_port_ctrl: a table of transfers, then directed cases.
module cfg_port_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        cp_out_valid, cp_out_ready = 1'b0;
    logic [31:0] cp_out_data;
    logic        cp_in_valid = 1'b0, cp_in_ready;
    logic [31:0] cp_in_data = '0;
    logic        cp_abort_n = 1'b1, cp_rb_busy = 1'b0, cp_aligned = 1'b1, cp_err = 1'b0;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [31:0] model [512];
    logic [31:0] got [1024];
    int got_n = 0, src_n = 0, cyc = 0;
    bit stall_mode = 0, sink_stall = 0;

    cfg_port_ctrl uut (.*);

    always #4 clk = ~clk;

    // Port models: sink for configure words, source for readback words
    always @(negedge clk) begin
        cyc = cyc + 1;
        cp_out_ready = sink_stall ? 1'b0 : (stall_mode ? (cyc % 3 != 0) : 1'b1);
        if (cp_out_valid && cp_out_ready) begin
            got[got_n] = cp_out_data;
            got_n = got_n + 1;
        end
        cp_in_valid = stall_mode ? (cyc % 2 == 0) : 1'b1;
        cp_in_data  = 32'hB000_0000 + src_n;
        if (cp_in_valid && cp_in_ready) src_n = src_n + 1;
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
    end

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic bus_read(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] stat_exp(bit done);
        return {23'd0, cp_err, cp_aligned, cp_rb_busy, cp_abort_n, 4'b1111, done};
    endfunction

    function automatic int clamp(int a);
        return (a > 511) ? 511 : a;
    endfunction

    task automatic wait_done(output bit ok);
        logic [31:0] s;
        ok = 0;
        for (int k = 0; k < 600; k++) begin
            bus_read(12'h80C, s);
            if (s[0]) begin ok = 1; break; end
        end
    endtask

    // dir (1 = readback), offset, size in bytes, stall
    localparam int NV = 8;
    localparam int VEC [NV][4] = '{
        '{0,   0, 32, 0},
        '{0, 100, 20, 1},
        '{1,  40, 24, 0},
        '{1, 300, 12, 1},
        '{0,  40, 24, 1},
        '{0, 508, 16, 0},
        '{0, 510, 16, 1},   // R9 clamp on configure
        '{1, 511,  8, 0}    // R9 clamp on readback
    };

    initial begin
        logic [31:0] r;
        bit ok;
        int bad, nw, off, s0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state, R6 status layout with idle flags
        bus_read(12'h80C, r); check(r == stat_exp(1), "R1/R6 status after reset", r, stat_exp(1));
        bus_read(12'h800, r); check(r == 0, "R1 size after reset", r, 0);
        bus_read(12'h804, r); check(r == 0, "R1 offset after reset", r, 0);

        // R6 flag mirroring with the other polarity of each flag
        cp_abort_n = 0; cp_rb_busy = 1; cp_aligned = 0; cp_err = 1;
        bus_read(12'h80C, r); check(r == 32'h15F, "R6 flags mirrored", r, 32'h15F);
        cp_abort_n = 1; cp_rb_busy = 0; cp_aligned = 1; cp_err = 0;

        // R3 register readback
        bus_write(12'h800, 32'h0000_0ABE); bus_read(12'h800, r);
        check(r == 32'hABE, "R3 size readback", r, 32'hABE);
        bus_write(12'h804, 32'h0000_01C3); bus_read(12'h804, r);
        check(r == 32'h1C3, "R3 offset readback", r, 32'h1C3);

        // R2 buffer fill and spot readback
        for (int i = 0; i < 512; i++) begin
            model[i] = 32'hC000_0000 + i * 32'h0001_0003;
            bus_write(12'(i * 4), model[i]);
        end
        bus_read(12'h1F4, r); check(r == model[125], "R2 buffer readback", r, model[125]);
        bus_read(12'h7FC, r); check(r == model[511], "R2 last buffer word", r, model[511]);

        // Table of transfers: R4 configure, R5 readback, R7 done, R9 clamp
        for (int v = 0; v < NV; v++) begin
            off = VEC[v][1]; nw = VEC[v][2] / 4;
            stall_mode = VEC[v][3][0];
            bus_write(12'h800, VEC[v][2]);
            bus_write(12'h804, off);
            got_n = 0; s0 = src_n;
            bus_write(12'h808, VEC[v][0]);
            wait_done(ok);
            check(ok, "R7 done returns", 32'(ok), 1);
            bad = 0;
            if (VEC[v][0] == 0) begin
                check(got_n == nw, "R4 configure word count", got_n, nw);
                for (int j = 0; j < nw; j++)
                    if (got[j] != model[clamp(off + j)]) bad++;
                check(bad == 0, (off + nw > 512) ? "R9 clamped configure data" : "R4 configure data", bad, 0);
            end else begin
                check(src_n - s0 == nw, "R5 readback word count", src_n - s0, nw);
                for (int j = 0; j < nw; j++) model[clamp(off + j)] = 32'hB000_0000 + s0 + j;
                for (int j = 0; j < nw; j++) begin
                    bus_read(12'(clamp(off + j) * 4), r);
                    if (r != model[clamp(off + j)]) bad++;
                end
                bus_read(12'h000, r);
                if (r != model[0]) bad++;
                check(bad == 0, (off + nw > 512) ? "R9 clamped readback data" : "R5 readback data", bad, 0);
            end
        end
        stall_mode = 0;

        // R10 zero word count (bits 1:0 alone) starts nothing
        bus_write(12'h800, 3); got_n = 0;
        bus_write(12'h808, 0);
        bus_read(12'h80C, r); check(r[0] == 1, "R10 done stays set", r, stat_exp(1));
        repeat (5) @(negedge clk);
        check(got_n == 0, "R10 no port words", got_n, 0);

        // R3 low size bits ignored: 7 bytes moves one word
        bus_write(12'h800, 7); bus_write(12'h804, 5); got_n = 0;
        bus_write(12'h808, 0); wait_done(ok);
        check(got_n == 1 && got[0] == model[5], "R3 size bits 1:0 ignored", got_n, 1);

        // R7/R8/R12 with a stalled sink
        sink_stall = 1;
        bus_write(12'h800, 4); bus_write(12'h804, 20); got_n = 0; s0 = src_n;
        bus_write(12'h808, 0);
        bus_read(12'h80C, r); check(r[0] == 0, "R7 done clear while active", r, stat_exp(0));
        bus_write(12'h808, 1);
        bus_write(12'h014, 32'hDEAD_BEEF);
        bus_read(12'h014, r); check(r == 0, "R12 buffer read blocked while active", r, 0);
        sink_stall = 0; wait_done(ok);
        check(got_n == 1 && got[0] == model[20], "R8 running transfer unchanged", got_n, 1);
        check(src_n == s0, "R8 no readback started", src_n - s0, 0);
        bus_read(12'h014, r); check(r == model[5], "R12 buffer write dropped while active", r, model[5]);

        // R11 cancel by status write
        sink_stall = 1;
        bus_write(12'h800, 16); bus_write(12'h804, 0); got_n = 0;
        bus_write(12'h808, 0);
        repeat (3) @(negedge clk);
        bus_write(12'h80C, 32'h0000_FEFE);
        bus_read(12'h80C, r); check(r == stat_exp(1), "R11 done after cancel", r, stat_exp(1));
        sink_stall = 0;
        repeat (10) @(negedge clk);
        check(got_n == 0, "R11 no words after cancel", got_n, 0);

        summary();
    end
endmodule